// File: doc/BRIEF.md
# Strobe-Driven FIFO with Read Rewind

This block is a first-in first-out buffer of 512 nine-bit words that a neighbour drives with active-low write and read strobes instead of addresses. Internal write and read pointers step through storage on their own, so words come out in the order they went in. The ninth bit is carried like the others and can hold parity or a control mark. Three active-low flags report the fill state: empty, full, and more than half full.

All four strobes (write, read, clear, rewind) are asynchronous-style inputs. They pass through a synchronizer on the system clock, and the block acts on their edges or levels once they are synchronized. A read starts on the falling edge of the read strobe. A write is taken on the rising edge of the write strobe. Holding the rewind strobe low moves the read pointer back to location 0, so everything written since the last clear can be read again. The write pointer and the stored words are left as they are.

Applying the rewind is only meaningful while no more than 512 words have been written since the last clear. The write data must be held stable from the falling edge of the write strobe until that write has been taken.

Top module: `strobe_fifo`

## Requirements
- R1: While `clr_n` is low (after synchronization), `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `dout_oe` is 0. Both pointers return to location 0, so the first word written after the clear is the first word read.
- R2: Words are read out in the order they were written, with all nine bits unchanged, including bit 8.
- R3: A write is taken on the rising edge of `wr_strb_n` using the word on `din`. `empty_n` goes to 1 on that edge.
- R4: `full_n` goes to 0 on the falling edge of `wr_strb_n` that starts a write into the last free location. It returns to 1 on the next rising edge of `rd_strb_n`.
- R5: A read is taken on the falling edge of `rd_strb_n`. `dout` then holds the word at the read pointer, and `dout_oe` is 1 until `rd_strb_n` rises. `empty_n` goes to 0 on the falling edge that takes the last stored word.
- R6: `half_n` goes to 0 on the falling edge of `wr_strb_n` that brings the fill level, counting the pending write, above DEPTH/2. It returns to 1 on a rising edge of `rd_strb_n` at which the fill level is DEPTH/2 or below.
- R7: A write attempted while the buffer holds DEPTH words is ignored: the flags, the pointers and the stored words do not change.
- R8: A read attempted while the buffer is empty is ignored: `dout_oe` stays 0, the flags stay as they were, and the read pointer does not move.
- R9: While `rewind_n` is low, the read pointer is held at location 0 and reads are ignored. The write pointer and the stored words are unchanged. All three flags are recomputed from the fill level.
- R10: The pointers wrap past the end of storage, so the buffer keeps working after more than DEPTH words in total have passed through it.
- R11: Each strobe change takes effect SYNC_STAGES+1 rising clock edges after the strobe changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the strobes are sampled |
| din | input | DATA_W | Word to be written |
| wr_strb_n | input | 1 | Active-low write strobe |
| rd_strb_n | input | 1 | Active-low read strobe |
| clr_n | input | 1 | Active-low clear of pointers and flags |
| rewind_n | input | 1 | Active-low retransmit: hold the read pointer at location 0 |
| dout | output | DATA_W | Word taken by the most recent read |
| dout_oe | output | 1 | High while an accepted read strobe is still low |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |
| half_n | output | 1 | Active-low more-than-half-full flag |

## Verification
Every result follows a strobe change by SYNC_STAGES+1 rising clock edges: two synchronizer stages, then the edge detector and the state registers update together. The bench changes a strobe at a falling clock edge and samples four rising edges later at the following falling edge, one edge after the result is due. One targeted check samples `empty_n` after only two rising edges following a write strobe's rise and expects the old value, then samples it one edge later and expects the new value. The fill, overflow, drain, underflow, rewind and wrap sequences all run on a sixteen-word configuration, with expected flags and data computed from a queue model.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Index of each edge-detected strobe in the event vectors of the top module.
  localparam int unsigned EV_WR = 0;
  localparam int unsigned EV_RD = 1;
  localparam int unsigned N_EV  = 2;

  // Index of each level-only strobe.
  localparam int unsigned LV_CLR = 0;
  localparam int unsigned LV_RWD = 1;
  localparam int unsigned N_LV   = 2;

  // Fill level reaches the capacity of the buffer.
  function automatic logic at_capacity(input int fill, input int depth);
    return fill >= depth;
  endfunction

  // Fill level strictly above half of the capacity.
  function automatic logic above_half(input int fill, input int depth);
    return fill > (depth / 2);
  endfunction

endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) chain_q[0] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sfifo_edge.sv
module sfifo_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic strb_n,
  output logic fall,
  output logic rise
);
  logic lvl;
  logic prev_q;

  sfifo_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .async_in (strb_n),
    .sync_out (lvl)
  );

  always_ff @(posedge clk) prev_q <= lvl;

  assign fall = prev_q & ~lvl;
  assign rise = ~prev_q & lvl;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
  import sfifo_pkg::*;
#(
  parameter int PW    = 10,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          clr_act,
  input  logic          empty_upd,
  input  logic          level_upd,
  input  logic [PW-1:0] count_nx,
  input  logic [PW-1:0] fill_nx,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  always_ff @(posedge clk) begin
    if (clr_act) begin
      empty_n <= 1'b0;
      full_n  <= 1'b1;
      half_n  <= 1'b1;
    end else begin
      if (empty_upd) empty_n <= (count_nx != '0);
      if (level_upd) begin
        full_n <= ~at_capacity(int'(fill_nx), DEPTH);
        half_n <= ~above_half(int'(fill_nx), DEPTH);
      end
    end
  end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import sfifo_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_strb_n,
  input  logic              rd_strb_n,
  input  logic              clr_n,
  input  logic              rewind_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  // Strobe conditioning
  logic [N_EV-1:0] ev_raw, ev_fall, ev_rise;
  logic [N_LV-1:0] lv_raw, lv_sync;

  assign ev_raw[EV_WR]  = wr_strb_n;
  assign ev_raw[EV_RD]  = rd_strb_n;
  assign lv_raw[LV_CLR] = clr_n;
  assign lv_raw[LV_RWD] = rewind_n;

  for (genvar g = 0; g < N_EV; g++) begin : g_edge
    sfifo_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .strb_n (ev_raw[g]),
      .fall   (ev_fall[g]),
      .rise   (ev_rise[g])
    );
  end

  for (genvar g = 0; g < N_LV; g++) begin : g_level
    sfifo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .async_in (lv_raw[g]),
      .sync_out (lv_sync[g])
    );
  end

  // Named internal events
  logic clr_act, rt_act, wr_arm, wr_commit, rd_fall, rd_take, rd_release;
  logic [PW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [PW-1:0] count, count_nx, fill_nx;
  logic armed_q, armed_nx, rd_live_q;
  logic [DATA_W-1:0] rdata, dout_q;

  assign clr_act    = ~lv_sync[LV_CLR];
  assign rt_act     = ~clr_act & ~lv_sync[LV_RWD];
  assign count      = wptr_q - rptr_q;
  assign wr_arm     = ~clr_act & ev_fall[EV_WR] &
                      ~at_capacity(int'(count) + int'(armed_q), DEPTH);
  assign wr_commit  = ~clr_act & ev_rise[EV_WR] & armed_q;
  assign rd_fall    = ~clr_act & ev_fall[EV_RD];
  assign rd_take    = rd_fall & ~rt_act & (count != '0);
  assign rd_release = ~clr_act & ev_rise[EV_RD];

  always_comb begin
    wptr_nx  = wptr_q + PW'(wr_commit);
    rptr_nx  = rt_act ? '0 : rptr_q + PW'(rd_take);
    armed_nx = wr_arm | (armed_q & ~ev_rise[EV_WR]);
    count_nx = wptr_nx - rptr_nx;
    fill_nx  = count_nx + PW'(armed_nx);
  end

  always_ff @(posedge clk) begin
    if (clr_act) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      armed_q   <= 1'b0;
      rd_live_q <= 1'b0;
    end else begin
      wptr_q  <= wptr_nx;
      rptr_q  <= rptr_nx;
      armed_q <= armed_nx;
      if (rd_take)         rd_live_q <= 1'b1;
      else if (rd_release) rd_live_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_take) dout_q <= rdata;
  end

  sfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (wr_commit),
    .waddr (wptr_q[ADDR_W-1:0]),
    .wdata (din),
    .raddr (rptr_q[ADDR_W-1:0]),
    .rdata (rdata)
  );

  sfifo_flags #(.PW(PW), .DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .clr_act   (clr_act),
    .empty_upd (rd_take | wr_commit | rt_act),
    .level_upd (wr_arm | rd_release | rt_act),
    .count_nx  (count_nx),
    .fill_nx   (fill_nx),
    .empty_n   (empty_n),
    .full_n    (full_n),
    .half_n    (half_n)
  );

  assign dout    = dout_q;
  assign dout_oe = rd_live_q;
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int PW    = 10,
  parameter int DEPTH = 512
) (
  input logic          clk,
  input logic          clr_act,
  input logic          rt_act,
  input logic          rd_fall,
  input logic          rd_take,
  input logic          wr_commit,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] count,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n
);
  p_clear_state_r1: assert property (@(posedge clk)
    clr_act |=> (!empty_n && full_n && half_n && wptr == '0 && rptr == '0));

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (clr_act)
    !(!empty_n && !full_n));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (clr_act)
    int'(count) <= DEPTH);

  p_commit_steps_r3: assert property (@(posedge clk) disable iff (clr_act)
    wr_commit |=> wptr == PW'($past(wptr) + PW'(1)));

  p_take_steps_r5: assert property (@(posedge clk) disable iff (clr_act)
    (rd_take && !rt_act) |=> rptr == PW'($past(rptr) + PW'(1)));

  p_empty_read_ignored_r8: assert property (@(posedge clk) disable iff (clr_act)
    (rd_fall && count == '0 && !rt_act) |=> $stable(rptr));

  p_rewind_r9: assert property (@(posedge clk) disable iff (clr_act)
    (rt_act && !wr_commit) |=> (rptr == '0 && $stable(wptr)));

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (clr_act)
    (!rd_take && !wr_commit && !rt_act) |=> $stable(empty_n));
endmodule

bind strobe_fifo sfifo_checker #(.PW(PW), .DEPTH(DEPTH)) u_sfifo_checker (
  .clk       (clk),
  .clr_act   (clr_act),
  .rt_act    (rt_act),
  .rd_fall   (rd_fall),
  .rd_take   (rd_take),
  .wr_commit (wr_commit),
  .wptr      (wptr_q),
  .rptr      (rptr_q),
  .count     (count),
  .empty_n   (empty_n),
  .full_n    (full_n),
  .half_n    (half_n)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [DW-1:0] din = '0;
  logic wr_n = 1'b1, rd_n = 1'b1, clr_n = 1'b0, rw_n = 1'b1;
  logic [DW-1:0] dout;
  logic dout_oe, empty_n, full_n, half_n;

  strobe_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_strobe_fifo (
    .clk       (clk),
    .din       (din),
    .wr_strb_n (wr_n),
    .rd_strb_n (rd_n),
    .clr_n     (clr_n),
    .rewind_n  (rw_n),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .empty_n   (empty_n),
    .full_n    (full_n),
    .half_n    (half_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] hist[$];
  logic e_empty = 1'b0, e_full = 1'b1, e_half = 1'b1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_flags(input string req);
    chk(req, "empty_n", int'(empty_n), int'(e_empty));
    chk(req, "full_n",  int'(full_n),  int'(e_full));
    chk(req, "half_n",  int'(half_n),  int'(e_half));
  endtask

  task automatic level_flags();
    e_full = (q.size() == DEPTH) ? 1'b0 : 1'b1;
    e_half = (q.size() > DEPTH / 2) ? 1'b0 : 1'b1;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 73 + 11) % 512);
  endfunction

  task automatic do_reset();
    clr_n = 1'b0;
    tick(6);
    clr_n = 1'b1;
    tick(4);
    q.delete();
    hist.delete();
    e_empty = 1'b0; e_full = 1'b1; e_half = 1'b1;
    chk_flags("R1");
    chk("R1", "dout_oe", int'(dout_oe), 0);
  endtask

  task automatic do_write(input logic [DW-1:0] d, input string req);
    bit acc;
    din = d;
    wr_n = 1'b0;
    tick(4);
    acc = (q.size() < DEPTH);
    if (acc) begin
      e_full = (q.size() + 1 == DEPTH) ? 1'b0 : 1'b1;
      e_half = (q.size() + 1 > DEPTH / 2) ? 1'b0 : 1'b1;
    end
    chk_flags(req);
    wr_n = 1'b1;
    tick(4);
    if (acc) begin
      q.push_back(d);
      hist.push_back(d);
      e_empty = 1'b1;
    end
    chk_flags(req);
  endtask

  task automatic do_read(input string req);
    logic [DW-1:0] exp;
    rd_n = 1'b0;
    tick(4);
    if (q.size() > 0) begin
      exp = q.pop_front();
      chk(req, "dout", int'(dout), int'(exp));
      chk(req, "dout_oe", int'(dout_oe), 1);
      e_empty = (q.size() != 0);
    end else begin
      chk("R8", "dout_oe on empty read", int'(dout_oe), 0);
    end
    chk_flags(req);
    rd_n = 1'b1;
    tick(4);
    level_flags();
    chk_flags(req);
    chk(req, "dout_oe after release", int'(dout_oe), 0);
  endtask

  task automatic do_rewind();
    rw_n = 1'b0;
    tick(4);
    q = hist;
    e_empty = (q.size() != 0);
    level_flags();
    chk_flags("R9");
    rw_n = 1'b1;
    tick(4);
    chk_flags("R9");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    tick(1);
    do_reset();

    // R11: first write, latency of the empty flag release
    din = pat(0);
    wr_n = 1'b0;
    tick(4);
    wr_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11", "empty_n before due edge", int'(empty_n), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "empty_n at due edge", int'(empty_n), 1);
    tick(2);
    q.push_back(pat(0));
    hist.push_back(pat(0));
    e_empty = 1'b1;
    chk_flags("R3");

    // Fill to capacity, crossing the half mark
    for (int i = 1; i < DEPTH; i++) begin
      do_write(pat(i), (i == DEPTH - 1) ? "R4" : ((i == DEPTH / 2) ? "R6" : "R3"));
    end

    // R7: write while full is ignored
    do_write(9'h1AA, "R7");

    // Read part of the content, then rewind
    for (int i = 0; i < 5; i++) do_read((i == 0) ? "R4" : "R7");
    do_rewind();

    // Drain everything, releasing half and asserting empty
    for (int i = 0; i < DEPTH; i++) begin
      do_read((q.size() == DEPTH / 2 + 1) ? "R6" : ((q.size() == 1) ? "R5" : "R2"));
    end

    // R8: read while empty, then confirm the pointer did not move
    do_read("R8");
    do_write(9'h155, "R8");
    do_read("R8");

    // R10: run past the end of storage twice
    for (int i = 0; i < 10; i++) do_write(pat(100 + i), "R10");
    for (int i = 0; i < 10; i++) do_read("R10");
    for (int i = 0; i < 12; i++) do_write(pat(200 + i), "R10");
    for (int i = 0; i < 12; i++) do_read("R10");

    // R1: clear with content present, then restart from location 0
    for (int i = 0; i < 3; i++) do_write(pat(300 + i), "R3");
    do_reset();
    do_read("R8");
    do_write(9'h100, "R1");
    do_read("R1");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule